// File: doc/BRIEF.md
# Bipolar Stepper Microstep Sequencer

This block keeps the electrical position of a two-phase bipolar stepper motor and turns it into two signed current references, one per phase, in percent of full scale. A slow step clock from outside is brought into the system clock domain. Each rising edge of the step clock moves the position by one step. The step size depends on the selected excitation resolution: full, half, eighth or sixteenth step. The direction input chooses whether the step is added or subtracted.

Position is a 6-bit index over one electrical cycle of 64 sixteenth-steps. A single quarter-wave magnitude table of 17 entries serves every resolution. Phase A reads the table at the index, and phase B reads it a quarter cycle further on. Each reference is then scaled by a torque ratio.

An active-low reset parks the sequencer at a fixed home position for each mode. An enable input switches the outputs off while the position keeps counting. The analog current loop that follows takes the two references as its targets.

Top module: `stepper_seq`

## Requirements
- R1: The mode input selects the step size in sixteenths of a quarter cycle: 0 = full step (16), 1 = half step (8), 2 = sixteenth step (1), 3 = eighth step (2).
- R2: The quarter-wave magnitudes for r = 0..16 are 100,100,98,96,92,88,83,77,71,63,56,47,38,29,20,10,0. For an index k, let q = k[5:4] and r = k[3:0]. The magnitude is T[r] when q is 0 or 2, and T[16-r] when q is 1 or 3. The sign is negative when q is 1 or 2. Phase A uses k = position and phase B uses k = position + 16 (mod 64).
- R3: In full-step mode each phase reference has magnitude 100, with the sign rule of R2.
- R4: With the direction input at 0 the step is added to the position, and at 1 it is subtracted, both modulo 64.
- R5: While reset is low the step clock and direction have no effect and the position is the mode's home: 8 in full-step mode (A = +100, B = -100) and 0 in the other modes (A = 100, B = 0).
- R6: The home flag is 1 exactly when the current position equals the home position of the current mode.
- R7: Each rising step-clock edge changes the position once. The new position appears after the third system clock edge that samples the step clock high. The first edge after reset release moves to the state that follows home.
- R8: With enable low the off flag is 1 and both references are 0, while the position keeps advancing. When enable returns high, the outputs show the position reached.
- R9: The torque input scales both references to trunc(magnitude × p / 100), with the sign applied after scaling, where p = 100, 75, 50, 20 for codes 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset to the home position |
| step_clk | input | 1 | Asynchronous step clock; a rising edge advances the position |
| dir_ccw | input | 1 | Step direction: 0 adds, 1 subtracts |
| mode | input | 2 | Excitation resolution select |
| torque | input | 2 | Torque ratio select |
| enable | input | 1 | Output enable; low switches the outputs off |
| ref_a | output | 8 | Signed phase A current reference, percent |
| ref_b | output | 8 | Signed phase B current reference, percent |
| at_home | output | 1 | High when the position is the mode's home |
| out_off | output | 1 | High when the outputs are switched off |

## Verification
The sequencer is driven with single steps in each resolution, so that the different step sizes and the full-step magnitude override show up as different reference pairs. Runs of steps in both directions cover the wrap of the 6-bit index past zero, along with a full 64-step revolution that must land back on home. Step pulses issued while reset is low check that reset ignores the clock. Steps taken while disabled, followed by re-enabling, separate an enable that only gates the outputs from one that freezes counting. Every torque code is applied at a non-trivial magnitude so that the truncation of each ratio is visible. A behavioural model compares both references and both flags on every clock.

// File: rtl/stepper_seq.sv
module stepper_seq (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_clk,
  input  logic              dir_ccw,
  input  logic [1:0]        mode,
  input  logic [1:0]        torque,
  input  logic              enable,
  output logic signed [7:0] ref_a,
  output logic signed [7:0] ref_b,
  output logic              at_home,
  output logic              out_off
);

  function automatic logic [6:0] qmag(input logic [4:0] r);
    case (r)
      5'd0, 5'd1: qmag = 7'd100;
      5'd2:  qmag = 7'd98;
      5'd3:  qmag = 7'd96;
      5'd4:  qmag = 7'd92;
      5'd5:  qmag = 7'd88;
      5'd6:  qmag = 7'd83;
      5'd7:  qmag = 7'd77;
      5'd8:  qmag = 7'd71;
      5'd9:  qmag = 7'd63;
      5'd10: qmag = 7'd56;
      5'd11: qmag = 7'd47;
      5'd12: qmag = 7'd38;
      5'd13: qmag = 7'd29;
      5'd14: qmag = 7'd20;
      5'd15: qmag = 7'd10;
      default: qmag = 7'd0;
    endcase
  endfunction

  function automatic logic [6:0] wave_mag(input logic [5:0] k);
    wave_mag = k[4] ? qmag(5'd16 - {1'b0, k[3:0]}) : qmag({1'b0, k[3:0]});
  endfunction

  logic [2:0] sync;
  logic [5:0] idx, home, pos, step, pos_b;
  logic       rise;
  logic [6:0] pct, mag_a, mag_b;
  logic [13:0] prod_a, prod_b, sc_a, sc_b;
  logic       neg_a, neg_b;

  assign home = (mode == 2'd0) ? 6'd8 : 6'd0;

  always_comb begin
    case (mode)
      2'd0: step = 6'd16;
      2'd1: step = 6'd8;
      2'd2: step = 6'd1;
      default: step = 6'd2;
    endcase
    case (torque)
      2'd0: pct = 7'd100;
      2'd1: pct = 7'd75;
      2'd2: pct = 7'd50;
      default: pct = 7'd20;
    endcase
  end

  assign rise = sync[1] & ~sync[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= 3'b000;
      idx  <= home;
    end else begin
      sync <= {sync[1:0], step_clk};
      if (rise) idx <= dir_ccw ? idx - step : idx + step;
    end
  end

  assign pos   = rst_n ? idx : home;
  assign pos_b = pos + 6'd16;
  assign neg_a = pos[5] ^ pos[4];
  assign neg_b = pos_b[5] ^ pos_b[4];
  assign mag_a = (mode == 2'd0) ? 7'd100 : wave_mag(pos);
  assign mag_b = (mode == 2'd0) ? 7'd100 : wave_mag(pos_b);

  assign prod_a = mag_a * pct;
  assign prod_b = mag_b * pct;
  assign sc_a   = prod_a / 14'd100;
  assign sc_b   = prod_b / 14'd100;

  assign ref_a = !enable ? 8'sd0 : (neg_a ? -$signed({1'b0, sc_a[6:0]}) : $signed({1'b0, sc_a[6:0]}));
  assign ref_b = !enable ? 8'sd0 : (neg_b ? -$signed({1'b0, sc_b[6:0]}) : $signed({1'b0, sc_b[6:0]}));
  assign at_home = (pos == home);
  assign out_off = ~enable;

  assert_step_fine_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && mode == 2'd2) |=> (idx == $past(idx) + 6'd1 || idx == $past(idx) - 6'd1))
    else $error("sixteenth step size wrong");

  assert_hold_no_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(idx))
    else $error("position moved without step edge");

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (ref_a == 8'sd0 && ref_b == 8'sd0 && out_off))
    else $error("outputs live while disabled");

  assert_home_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_home && enable && torque == 2'd0 && mode != 2'd0) |-> (ref_a == 8'sd100 && ref_b == 8'sd0))
    else $error("home reference wrong");

  assert_ref_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_a <= 8'sd100 && ref_a >= -8'sd100 && ref_b <= 8'sd100 && ref_b >= -8'sd100))
    else $error("reference out of range");

endmodule

// File: tb/sim_stepper_seq.sv
module sim_stepper_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0, step_clk = 1'b0, dir_ccw = 1'b0, enable = 1'b1;
  logic [1:0] mode = 2'd0, torque = 2'd0;
  logic signed [7:0] ref_a, ref_b;
  logic at_home, out_off;

  int tests = 0, fails = 0;
  int idx_m = 8;
  int q[$] = '{0, 0, 0};
  localparam int TBL[17] = '{100,100,98,96,92,88,83,77,71,63,56,47,38,29,20,10,0};

  always #10 clk = ~clk;

  stepper_seq u0 (.clk(clk), .rst_n(rst_n), .step_clk(step_clk), .dir_ccw(dir_ccw),
    .mode(mode), .torque(torque), .enable(enable), .ref_a(ref_a), .ref_b(ref_b),
    .at_home(at_home), .out_off(out_off));

  function automatic int home_of(int md); return (md == 0) ? 8 : 0; endfunction
  function automatic int step_of(int md);
    case (md) 0: return 16; 1: return 8; 2: return 1; default: return 2; endcase
  endfunction
  function automatic int wav(int k, int md, int tq, bit en);
    int qd, r, m, p, v;
    k = ((k % 64) + 64) % 64; qd = k / 16; r = k % 16;
    m = (qd == 1 || qd == 3) ? TBL[16 - r] : TBL[r];
    if (md == 0) m = 100;
    case (tq) 0: p = 100; 1: p = 75; 2: p = 50; default: p = 20; endcase
    v = (m * p) / 100;
    if (!en) return 0;
    return (qd == 1 || qd == 2) ? -v : v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      idx_m = home_of(mode);
      q = '{0, 0, 0};
    end else begin
      if (q[1] == 1 && q[2] == 0)
        idx_m = (((dir_ccw ? idx_m - step_of(mode) : idx_m + step_of(mode)) % 64) + 64) % 64;
      q.push_front(int'(step_clk));
      void'(q.pop_back());
    end
  end

  always @(negedge clk) begin
    int p;
    p = rst_n ? idx_m : home_of(mode);
    chk(mode == 0 ? "R3 ref_a" : "R2 ref_a", ref_a, wav(p, mode, torque, enable));
    chk(mode == 0 ? "R3 ref_b" : "R2 ref_b", ref_b, wav(p + 16, mode, torque, enable));
    chk("R6 at_home", at_home, int'(p == home_of(mode)));
    chk("R8 out_off", out_off, int'(!enable));
  end

  task automatic pulse();
    step_clk = 1'b1; repeat (3) @(negedge clk);
    step_clk = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic rehome(int md);
    rst_n = 1'b0; mode = 2'(md); repeat (2) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R5 reset full A", ref_a, 100);
    chk("R5 reset full B", ref_b, -100);
    chk("R6 reset home", at_home, 1);
    mode = 2'd1; @(negedge clk);
    chk("R5 reset half A", ref_a, 100);
    chk("R5 reset half B", ref_b, 0);
    pulse(); pulse();
    chk("R5 clock ignored A", ref_a, 100);
    chk("R5 clock ignored home", at_home, 1);

    rehome(0); pulse();
    chk("R3 full step A", ref_a, -100);
    chk("R3 full step B", ref_b, -100);

    rehome(2);
    step_clk = 1'b1; @(negedge clk); @(negedge clk);
    chk("R7 latency hold", ref_b, 0);
    @(negedge clk);
    chk("R7 first step B", ref_b, -10);
    chk("R7 first step A", ref_a, 100);
    step_clk = 1'b0; repeat (3) @(negedge clk);

    rehome(3); pulse();
    chk("R1 eighth A", ref_a, 98);
    chk("R1 eighth B", ref_b, -20);

    rehome(1); dir_ccw = 1'b1; pulse();
    chk("R4 ccw A", ref_a, 71);
    chk("R4 ccw B", ref_b, 71);
    dir_ccw = 1'b0; pulse(); pulse();
    chk("R4 cw A", ref_a, 71);
    chk("R4 cw B", ref_b, -71);

    rehome(2); dir_ccw = 1'b1; pulse();
    chk("R4 wrap A", ref_a, 100);
    chk("R4 wrap B", ref_b, 10);
    chk("R6 off home", at_home, 0);
    dir_ccw = 1'b0;
    for (int i = 0; i < 65; i++) pulse();
    chk("R6 revolution home", at_home, 1);

    rehome(1); enable = 1'b0;
    for (int i = 0; i < 4; i++) pulse();
    chk("R8 disabled A", ref_a, 0);
    chk("R8 off flag", out_off, 1);
    enable = 1'b1; @(negedge clk);
    chk("R8 resume A", ref_a, -100);
    chk("R8 resume B", ref_b, 0);

    rehome(2);
    for (int i = 0; i < 8; i++) pulse();
    for (int t = 0; t < 4; t++) begin
      torque = 2'(t); @(negedge clk);
      chk("R9 torque A", ref_a, (t == 0) ? 71 : (t == 1) ? 53 : (t == 2) ? 35 : 14);
      chk("R9 torque B", ref_b, (t == 0) ? -71 : (t == 1) ? -53 : (t == 2) ? -35 : -14);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule